// File: doc/BRIEF.md
# Display Controller Register File with Indexed Tables

This block is the configuration store of a display controller. A host reaches it over a simple strobe bus with an 8-bit byte address, 16-bit write data and a registered 16-bit read port. It holds identification constants, a clock-synthesizer divider, synthesizer control and memory refresh words, panel width, border colour, power and status bytes. The datapath that consumes these values lies outside the block.

Two lookup tables are reached through a pair of registers each: an index register and a data port. An access to the data port touches the entry at the current index and then moves the index forward by one. The 32-entry filter-coefficient table stops advancing once its index is past the last entry. The 256-entry gamma table lets its 8-bit index wrap from 0xFF to 0x00. Some reads return computed values: the divider is stored plus one, the panel width reads back in units of eight pixels, and one status bit always reads as one.

Top module: `disp_regfile`

## Requirements
- R1: After reset, reads return: 0x06 → 0x01, 0x0C → 0x32, 0x28 → 0x74, 0x56 → 0x80, 0xA8 → 0x10, 0xAA → 0x80, 0xAC → 0x80, 0xE6 → 0x02, 0xF8 → 0xFF, 0x58 → 0x00, 0xB6 → 0x00. A byte register stores wdata[7:0] on a write; at 0x06 only bits 1:0 are kept.
- R2: Address 0x00 always reads 0x00A5 and address 0x02 always reads 0x0083. Writes to them change nothing.
- R3: A write of v to 0x04 stores (v & 0x3F) + 1. A read returns (stored − 1) with bit 7 set. The stored value after reset is 9, so the reset read is 0x0088.
- R4: Two 16-bit words are split into bytes. The synthesizer control word uses 0x08 (low) and 0x0A (high), reset 0x0014. The refresh interval uses 0x18 (low) and 0x1A (high), reset 0x025C. A write to either half replaces only that byte with wdata[7:0].
- R5: A write to 0x2A stores the full 16-bit pixel width. A read returns the width shifted right by 3. The reset width is 8, which reads as 0x0001.
- R6: The status byte at 0xE8 resets to 0x00 and always reads with bit 5 set.
- R7: The filter index is at 0x58 and the filter data port at 0x5A. While the index is below 32, a data-port read returns the entry at the index, a data-port write stores wdata[7:0] there, and either one increments the index. At an index of 32 or above, a read returns 0, a write is dropped, and the index holds.
- R8: The gamma index is at 0xB6 and the gamma data port at 0xB8. A data-port read or write uses the entry at the index and then increments the 8-bit index, which wraps from 0xFF to 0x00.
- R9: A read of any address not listed in R1–R8 (this includes every odd address) returns 0 and raises rd_err for exactly the one cycle in which that read data is presented. Writes to such addresses change no register.
- R10: rdata and rd_err update on the clock edge after a cycle with rd_en high, and rdata holds its value otherwise. When wr_en and rd_en are high together, only the write takes effect: rdata holds and no index moves for the read. rdata and rd_err reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current cycle |
| rd_en | input | 1 | Read strobe for the current cycle |
| addr | input | 8 | Byte address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| rd_err | output | 1 | One-cycle flag for a read of an unmapped address |

## Verification
The hardest states to reach are at the ends of the tables: the filter index sitting at 32 or beyond, and the gamma index crossing 0xFF. Both are reached only through long runs of data-port accesses, or by writing an index register directly. The bench fills both tables with streams of auto-incrementing writes. It places indices next to each boundary and reads across it. Constrained random traffic then mixes direct index writes (often past 32) with data-port reads and writes, and a bench model predicts every index step.

// File: rtl/disp_rf_pkg.sv
package disp_rf_pkg;

  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;

  typedef logic [ADDR_W-1:0] raddr_t;
  typedef logic [7:0]        rbyte_t;

  // fixed and special addresses
  localparam raddr_t A_IDENT     = 8'h00;
  localparam raddr_t A_CONFIG    = 8'h02;
  localparam raddr_t A_PLLDIV    = 8'h04;
  localparam raddr_t A_PLLCTL_LO = 8'h08;
  localparam raddr_t A_PLLCTL_HI = 8'h0A;
  localparam raddr_t A_REFR_LO   = 8'h18;
  localparam raddr_t A_REFR_HI   = 8'h1A;
  localparam raddr_t A_HWIDTH    = 8'h2A;
  localparam raddr_t A_FIDX      = 8'h58;
  localparam raddr_t A_FDATA     = 8'h5A;
  localparam raddr_t A_GIDX      = 8'hB6;
  localparam raddr_t A_GDATA     = 8'hB8;
  localparam raddr_t A_STATUS    = 8'hE8;

  localparam rbyte_t IDENT_VAL    = 8'hA5;
  localparam rbyte_t CONFIG_VAL   = 8'h83;
  localparam rbyte_t STATUS_FORCE = 8'h20;

  localparam logic [6:0]  PLLDIV_RST = 7'd9;
  localparam logic [15:0] PLLCTL_RST = 16'h0014;
  localparam logic [15:0] REFR_RST   = 16'h025C;
  localparam logic [15:0] HWIDTH_RST = 16'd8;

  // plain byte registers: address, reset value, write mask
  localparam int NBYTE = 10;
  localparam raddr_t BYTE_ADDR [NBYTE] = '{8'h06, 8'h0C, 8'h28, 8'h56, 8'hA8,
                                           8'hAA, 8'hAC, 8'hE6, 8'hE8, 8'hF8};
  localparam rbyte_t BYTE_RST  [NBYTE] = '{8'h01, 8'h32, 8'h74, 8'h80, 8'h10,
                                           8'h80, 8'h80, 8'h02, 8'h00, 8'hFF};
  localparam rbyte_t BYTE_MASK [NBYTE] = '{8'h03, 8'hFF, 8'hFF, 8'hFF, 8'hFF,
                                           8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};

endpackage

// File: rtl/rf_byte_reg.sv
module rf_byte_reg #(
  parameter logic [7:0] RST  = 8'h00,
  parameter logic [7:0] MASK = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wbyte,
  output logic [7:0] q
);

  logic [7:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (we) q_nxt = wbyte & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/rf_split16.sv
module rf_split16 #(
  parameter logic [15:0] RST = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we_lo,
  input  logic        we_hi,
  input  logic [7:0]  wbyte,
  output logic [15:0] q
);

  logic [15:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (we_lo) q_nxt[7:0]  = wbyte;
    if (we_hi) q_nxt[15:8] = wbyte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/rf_index_table.sv
module rf_index_table #(
  parameter int DEPTH   = 32,
  parameter int IDX_W   = 8,
  parameter int DW      = 8,
  parameter bit BOUNDED = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idx_we,
  input  logic [IDX_W-1:0] idx_wdata,
  input  logic             acc_rd,
  input  logic             acc_wr,
  input  logic [DW-1:0]    wdata,
  output logic [IDX_W-1:0] idx_q,
  output logic [DW-1:0]    rd_val
);

  localparam int MAW = $clog2(DEPTH);

  logic [DW-1:0]    mem [DEPTH];
  logic             in_range;
  logic [IDX_W-1:0] idx_nxt;
  logic [MAW-1:0]   slot;

  assign slot = idx_q[MAW-1:0];

  generate
    if (BOUNDED) begin : g_bounded
      localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(DEPTH);
      assign in_range = ({1'b0, idx_q} < LIMIT);
    end else begin : g_wrap
      assign in_range = 1'b1;
    end
  endgenerate

  always_comb begin
    idx_nxt = idx_q;
    if (idx_we)
      idx_nxt = idx_wdata;
    else if ((acc_rd || acc_wr) && in_range)
      idx_nxt = idx_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_nxt;
  end

  // table storage carries no reset
  always_ff @(posedge clk) begin
    if (acc_wr && in_range) mem[slot] <= wdata;
  end

  assign rd_val = in_range ? mem[slot] : '0;

endmodule

// File: rtl/disp_regfile.sv
module disp_regfile
  import disp_rf_pkg::*;
#(
  parameter int FILT_DEPTH = 32,
  parameter int GAM_DEPTH  = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        rd_err
);

  logic        rd_go;
  logic [7:0]  byte_q [NBYTE];
  logic [15:0] pllctl_q, refr_q, hwidth_q, hwidth_nxt;
  logic [6:0]  pll_q, pll_nxt, pll_m1;
  logic [7:0]  filt_idx, gam_idx, filt_val, gam_val;
  logic [15:0] rd_val, rdata_nxt;
  logic        rd_hit, err_nxt;

  assign rd_go = rd_en & ~wr_en;

  // plain byte registers
  genvar gi;
  generate
    for (gi = 0; gi < NBYTE; gi++) begin : g_byte
      rf_byte_reg #(.RST(BYTE_RST[gi]), .MASK(BYTE_MASK[gi])) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en && (addr == BYTE_ADDR[gi])),
        .wbyte (wdata[7:0]),
        .q     (byte_q[gi])
      );
    end
  endgenerate

  rf_split16 #(.RST(PLLCTL_RST)) u_pllctl (
    .clk   (clk),
    .rst_n (rst_n),
    .we_lo (wr_en && (addr == A_PLLCTL_LO)),
    .we_hi (wr_en && (addr == A_PLLCTL_HI)),
    .wbyte (wdata[7:0]),
    .q     (pllctl_q)
  );

  rf_split16 #(.RST(REFR_RST)) u_refr (
    .clk   (clk),
    .rst_n (rst_n),
    .we_lo (wr_en && (addr == A_REFR_LO)),
    .we_hi (wr_en && (addr == A_REFR_HI)),
    .wbyte (wdata[7:0]),
    .q     (refr_q)
  );

  rf_index_table #(.DEPTH(FILT_DEPTH), .IDX_W(8), .DW(8), .BOUNDED(1'b1)) u_filt (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_we    (wr_en && (addr == A_FIDX)),
    .idx_wdata (wdata[7:0]),
    .acc_rd    (rd_go && (addr == A_FDATA)),
    .acc_wr    (wr_en && (addr == A_FDATA)),
    .wdata     (wdata[7:0]),
    .idx_q     (filt_idx),
    .rd_val    (filt_val)
  );

  rf_index_table #(.DEPTH(GAM_DEPTH), .IDX_W(8), .DW(8), .BOUNDED(1'b0)) u_gam (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_we    (wr_en && (addr == A_GIDX)),
    .idx_wdata (wdata[7:0]),
    .acc_rd    (rd_go && (addr == A_GDATA)),
    .acc_wr    (wr_en && (addr == A_GDATA)),
    .wdata     (wdata[7:0]),
    .idx_q     (gam_idx),
    .rd_val    (gam_val)
  );

  // divider kept with an offset of one, and panel width in pixels
  always_comb begin
    pll_nxt    = pll_q;
    hwidth_nxt = hwidth_q;
    if (wr_en && (addr == A_PLLDIV)) pll_nxt    = {1'b0, wdata[5:0]} + 7'd1;
    if (wr_en && (addr == A_HWIDTH)) hwidth_nxt = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pll_q    <= PLLDIV_RST;
      hwidth_q <= HWIDTH_RST;
    end else begin
      pll_q    <= pll_nxt;
      hwidth_q <= hwidth_nxt;
    end
  end

  assign pll_m1 = pll_q - 7'd1;

  // read selection
  always_comb begin
    rd_val = '0;
    rd_hit = 1'b1;
    case (addr)
      A_IDENT:     rd_val = {8'h00, IDENT_VAL};
      A_CONFIG:    rd_val = {8'h00, CONFIG_VAL};
      A_PLLDIV:    rd_val = {8'h00, 1'b1, pll_m1};
      A_PLLCTL_LO: rd_val = {8'h00, pllctl_q[7:0]};
      A_PLLCTL_HI: rd_val = {8'h00, pllctl_q[15:8]};
      A_REFR_LO:   rd_val = {8'h00, refr_q[7:0]};
      A_REFR_HI:   rd_val = {8'h00, refr_q[15:8]};
      A_HWIDTH:    rd_val = {3'b000, hwidth_q[15:3]};
      A_FIDX:      rd_val = {8'h00, filt_idx};
      A_FDATA:     rd_val = {8'h00, filt_val};
      A_GIDX:      rd_val = {8'h00, gam_idx};
      A_GDATA:     rd_val = {8'h00, gam_val};
      default: begin
        rd_hit = 1'b0;
        for (int i = 0; i < NBYTE; i++) begin
          if (addr == BYTE_ADDR[i]) begin
            rd_val = {8'h00, byte_q[i]};
            rd_hit = 1'b1;
          end
        end
        if (addr == A_STATUS) rd_val[7:0] = rd_val[7:0] | STATUS_FORCE;
      end
    endcase
  end

  always_comb begin
    rdata_nxt = rdata;
    err_nxt   = 1'b0;
    if (rd_go) begin
      rdata_nxt = rd_val;
      err_nxt   = ~rd_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rd_err <= 1'b0;
    end else begin
      rdata  <= rdata_nxt;
      rd_err <= err_nxt;
    end
  end

endmodule

// File: rtl/disp_regfile_chk.sv
module disp_regfile_chk
  import disp_rf_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [7:0]  addr,
  input logic [15:0] rdata,
  input logic        rd_err,
  input logic [7:0]  filt_idx,
  input logic [7:0]  gam_idx
);

  logic rd_only, f_acc, g_acc;
  assign rd_only = rd_en && !wr_en;
  assign f_acc   = (rd_only || wr_en) && (addr == A_FDATA);
  assign g_acc   = (rd_only || wr_en) && (addr == A_GDATA);

  p_ident_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_only && addr == A_IDENT) |=> (rdata == 16'h00A5));

  p_pll_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_only && addr == A_PLLDIV) |=> (rdata[15:7] == 9'h001));

  p_status_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_only && addr == A_STATUS) |=> rdata[5]);

  p_filt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (f_acc && filt_idx < 8'd32) |=> (filt_idx == $past(filt_idx) + 8'd1));

  p_filt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (f_acc && filt_idx >= 8'd32) |=> $stable(filt_idx));

  p_gam_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    g_acc |=> (gam_idx == $past(gam_idx) + 8'd1));

  p_err_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> ($past(rd_only) && rdata == 16'h0000));

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_only |=> ($stable(rdata) && !rd_err));

endmodule

bind disp_regfile disp_regfile_chk u_chk (.*);

// File: tb/tb_disp_regfile.sv
`timescale 1ns/1ps
module tb_disp_regfile;

  logic        clk, rst_n, wr_en, rd_en;
  logic [7:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        rd_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  disp_regfile dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rd_err(rd_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- reference model ----------------
  logic [6:0]  m_pll;
  logic [15:0] m_pctl, m_refr, m_hw;
  logic [7:0]  m_byte [256];
  logic [7:0]  m_fidx, m_gidx;
  logic [7:0]  m_fmem [32];
  logic [7:0]  m_gmem [256];

  function automatic bit is_byte(input logic [7:0] a);
    case (a)
      8'h06, 8'h0C, 8'h28, 8'h56, 8'hA8, 8'hAA, 8'hAC, 8'hE6, 8'hE8, 8'hF8: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00, 8'h02: return "R2";
      8'h04: return "R3";
      8'h08, 8'h0A, 8'h18, 8'h1A: return "R4";
      8'h2A: return "R5";
      8'hE8: return "R6";
      8'h58, 8'h5A: return "R7";
      8'hB6, 8'hB8: return "R8";
      default: return is_byte(a) ? "R1" : "R9";
    endcase
  endfunction

  task automatic mdl_reset();
    m_pll = 7'd9; m_pctl = 16'h0014; m_refr = 16'h025C; m_hw = 16'd8;
    m_fidx = 8'h00; m_gidx = 8'h00;
    for (int i = 0; i < 256; i++) m_byte[i] = 8'h00;
    m_byte[8'h06] = 8'h01; m_byte[8'h0C] = 8'h32; m_byte[8'h28] = 8'h74;
    m_byte[8'h56] = 8'h80; m_byte[8'hA8] = 8'h10; m_byte[8'hAA] = 8'h80;
    m_byte[8'hAC] = 8'h80; m_byte[8'hE6] = 8'h02; m_byte[8'hE8] = 8'h00;
    m_byte[8'hF8] = 8'hFF;
  endtask

  task automatic mdl_write(input logic [7:0] a, input logic [15:0] d);
    case (a)
      8'h04: m_pll = 7'(d & 16'h3F) + 7'd1;
      8'h08: m_pctl[7:0]  = d[7:0];
      8'h0A: m_pctl[15:8] = d[7:0];
      8'h18: m_refr[7:0]  = d[7:0];
      8'h1A: m_refr[15:8] = d[7:0];
      8'h2A: m_hw = d;
      8'h58: m_fidx = d[7:0];
      8'h5A: if (m_fidx < 8'd32) begin m_fmem[m_fidx[4:0]] = d[7:0]; m_fidx++; end
      8'hB6: m_gidx = d[7:0];
      8'hB8: begin m_gmem[m_gidx] = d[7:0]; m_gidx++; end
      default: if (is_byte(a)) m_byte[a] = (a == 8'h06) ? (d[7:0] & 8'h03) : d[7:0];
    endcase
  endtask

  task automatic mdl_read(input logic [7:0] a, output logic [15:0] v, output bit hit);
    hit = 1'b1;
    v   = 16'h0000;
    case (a)
      8'h00: v = 16'h00A5;
      8'h02: v = 16'h0083;
      8'h04: v = 16'h0080 | 16'(m_pll - 7'd1);
      8'h08: v = {8'h00, m_pctl[7:0]};
      8'h0A: v = {8'h00, m_pctl[15:8]};
      8'h18: v = {8'h00, m_refr[7:0]};
      8'h1A: v = {8'h00, m_refr[15:8]};
      8'h2A: v = m_hw >> 3;
      8'h58: v = {8'h00, m_fidx};
      8'h5A: if (m_fidx < 8'd32) begin v = {8'h00, m_fmem[m_fidx[4:0]]}; m_fidx++; end
      8'hB6: v = {8'h00, m_gidx};
      8'hB8: begin v = {8'h00, m_gmem[m_gidx]}; m_gidx++; end
      8'hE8: v = {8'h00, m_byte[a] | 8'h20};
      default: begin
        if (is_byte(a)) v = {8'h00, m_byte[a]};
        else hit = 1'b0;
      end
    endcase
  endtask

  // ---------------- bus helpers ----------------
  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b0; addr = a; wdata = d;
    mdl_write(a, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a);
    logic [15:0] e;
    bit h;
    string t;
    t = tag_of(a);
    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b0; addr = a;
    mdl_read(a, e, h);
    @(negedge clk);
    rd_en = 1'b0;
    chk($sformatf("%s data @%h", t, a), rdata, e);
    chk($sformatf("%s err @%h", t, a), {15'b0, rd_err}, {15'b0, ~h});
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  logic [7:0] rst_list [20] = '{8'h00, 8'h02, 8'h04, 8'h06, 8'h08, 8'h0A, 8'h0C,
                                8'h18, 8'h1A, 8'h28, 8'h2A, 8'h56, 8'h58, 8'hA8,
                                8'hAA, 8'hAC, 8'hB6, 8'hE6, 8'hE8, 8'hF8};
  logic [7:0] rnd_list [28] = '{8'h00, 8'h02, 8'h04, 8'h06, 8'h08, 8'h0A, 8'h0C,
                                8'h18, 8'h1A, 8'h28, 8'h2A, 8'h56, 8'h58, 8'h5A,
                                8'h5A, 8'hA8, 8'hAA, 8'hAC, 8'hB6, 8'hB8, 8'hB8,
                                8'hE6, 8'hE8, 8'hF8, 8'h01, 8'h10, 8'h5B, 8'hFF};

  initial begin
    logic [15:0] held;
    void'($urandom(32'd4242));
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = 8'h00; wdata = 16'h0000;
    mdl_reset();
    repeat (3) @(negedge clk);
    chk("R10 reset rdata", rdata, 16'h0000);
    chk("R10 reset err", {15'b0, rd_err}, 16'h0000);
    rst_n = 1'b1;

    // R1..R6 reset values
    foreach (rst_list[i]) bus_read(rst_list[i]);

    // R2 constants ignore writes
    bus_write(8'h00, 16'h1234); bus_read(8'h00);
    bus_write(8'h02, 16'hFFFF); bus_read(8'h02);
    // R3 divider offset
    bus_write(8'h04, 16'h00FF); bus_read(8'h04);
    bus_write(8'h04, 16'h0040); bus_read(8'h04);
    // R4 split halves
    bus_write(8'h1A, 16'hAB12); bus_read(8'h18); bus_read(8'h1A);
    // R5 width
    bus_write(8'h2A, 16'h0007); bus_read(8'h2A);
    bus_write(8'h2A, 16'hF123); bus_read(8'h2A);
    // R6 status
    bus_write(8'hE8, 16'h0000); bus_read(8'hE8);
    bus_write(8'hE8, 16'h00DF); bus_read(8'hE8);
    // R1 mask on 0x06
    bus_write(8'h06, 16'h00FE); bus_read(8'h06);

    // R8 / R11-style fill of gamma table with wrap
    bus_write(8'hB6, 16'h0000);
    for (int i = 0; i < 256; i++) bus_write(8'hB8, 16'((i * 7 + 3) & 8'hFF));
    bus_read(8'hB6);
    bus_write(8'hB6, 16'h00FE);
    bus_read(8'hB8); bus_read(8'hB8); bus_read(8'hB8); bus_read(8'hB6);

    // R7 filter fill, then boundary
    bus_write(8'h58, 16'h0000);
    for (int i = 0; i < 32; i++) bus_write(8'h5A, 16'((i * 13 + 5) & 8'hFF));
    bus_read(8'h58);
    bus_write(8'h5A, 16'h00EE); bus_read(8'h58);
    bus_read(8'h5A); bus_read(8'h58);
    bus_write(8'h58, 16'h001E);
    bus_read(8'h5A); bus_read(8'h5A); bus_read(8'h5A); bus_read(8'h58);
    bus_write(8'h58, 16'h001F); bus_read(8'h5A);

    // R9 unmapped reads and writes
    bus_read(8'h01); bus_read(8'h10); bus_read(8'hFF);
    @(negedge clk);
    chk("R9 err single cycle", {15'b0, rd_err}, 16'h0000);
    bus_write(8'h05, 16'h0011); bus_read(8'h04);
    bus_write(8'h59, 16'h0003); bus_read(8'h58);

    // R10 simultaneous strobes: write only, rdata holds
    bus_read(8'h28);
    held = rdata;
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; addr = 8'h0C; wdata = 16'h0055;
    mdl_write(8'h0C, 16'h0055);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R10 rdata hold on write+read", rdata, held);
    repeat (2) @(negedge clk);
    chk("R10 rdata hold idle", rdata, held);
    bus_read(8'h0C);
    bus_write(8'hB6, 16'h0010);
    @(negedge clk);
    wr_en = 1'b1; rd_en = 1'b1; addr = 8'hB6; wdata = 16'h0020;
    mdl_write(8'hB6, 16'h0020);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    bus_read(8'hB6);

    // constrained random traffic
    for (int k = 0; k < 1500; k++) begin
      logic [7:0] a;
      logic [15:0] d;
      a = rnd_list[$urandom_range(0, 27)];
      d = 16'($urandom);
      if (a == 8'h58 && d[0]) d = {8'h00, 3'b000, d[5:1]};
      if ($urandom_range(0, 1) == 0) bus_write(a, d);
      else bus_read(a);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule